// File: doc/BRIEF.md
# Interrupt Register Spill Engine

This block works next to a small 16-register integer core. When the core takes an interrupt, the engine stores a fixed group of caller-saved registers onto the normal stack in data RAM. When the handler returns, it loads them back. It reads the register file through a combinational read port and writes it through a write port. Each stack word goes over a simple request/ready memory interface, one word at a time.

The engine moves the stack pointer (x2) itself. While a sequence is in progress it holds `busy` high, and it pulses `done` when the sequence ends. A per-request input selects one of two register sets: the full standard-ABI set of ten registers, or a reduced six-register set for the embedded ABI. The engine tracks up to two nested levels and records, for each level, which set was saved. A restore therefore always matches its save.

Top module: `ctx_stack_engine`

## Requirements
- R1: With `abi_sel`=0 at entry, exactly ten registers are stored, in this order: x1, x5, x6, x7, x10, x11, x12, x13, x14, x15. Slot k of that list goes to address new_sp+4k.
- R2: With `abi_sel`=1 at entry, exactly six registers are stored, in this order: x5, x10, x11, x12, x13, x15. Slot k goes to new_sp+4k.
- R3: Registers x8 and x9 are never written by the engine. A restore writes only the registers of the matching set plus x2, and every other register keeps its value.
- R4: On entry, x2 is lowered by 4×N, where N is the set size. On return, x2 is raised by 4×N. Every access is word aligned, and a request holds its address and direction until `mem_ready` is high.
- R5: `done` is high for exactly one cycle, after the last store (entry) or after the stack-pointer write-back (return). `busy` is high from the cycle after an accepted request through the `done` cycle. After reset, `busy`, `done` and `mem_req` are low.
- R6: `depth` starts at 0. It goes up by one after a completed save and down by one after a completed restore, and it changes only on a `done` cycle. It never exceeds 2.
- R7: An entry request at depth 2 pulses `overflow` for one cycle. It makes no memory access and leaves `depth` unchanged.
- R8: A return request at depth 0 pulses `underflow` for one cycle. It makes no memory access and leaves `depth` unchanged.
- R9: A restore uses the register set recorded for its level at save time, whatever `abi_sel` is when the restore is requested.
- R10: Entry and return requests that arrive while `busy` is high are ignored. When both requests are raised in the same idle cycle, the entry request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Interrupt entry: save context |
| return_req | input | 1 | Handler return: restore context |
| abi_sel | input | 1 | 0 = standard ten-register set, 1 = reduced six-register set |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts / completes the access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| depth | output | 2 | Current nesting level |
| overflow | output | 1 | Entry refused at full depth (pulse) |
| underflow | output | 1 | Return refused at zero depth (pulse) |

## Verification
The bench builds the engine with its defaults: 32-bit data and addresses and a nesting limit of two. With those values the overflow refusal is reached after only two saves, and one save/restore of each set can be nested under the other with mismatched `abi_sel`. The bench memory model inserts wait states on `mem_ready`, so the hold-while-waiting behaviour and the stack-pointer arithmetic are exercised against a RAM that stalls.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int RIDX_W = 4;
    localparam logic [RIDX_W-1:0] SP_IDX = 4'd2;

    typedef enum logic {
        ABI_STD = 1'b0,
        ABI_EMB = 1'b1
    } abi_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SP_DEC,
        ST_STORE,
        ST_SP_GET,
        ST_LOAD,
        ST_SP_INC,
        ST_DONE
    } ctx_state_e;

    // number of stack slots used by a register set
    function automatic logic [3:0] slot_count(abi_e m);
        return (m == ABI_STD) ? 4'd10 : 4'd6;
    endfunction

    // register index held in slot k of a register set
    function automatic logic [RIDX_W-1:0] slot_reg(abi_e m, logic [3:0] k);
        logic [RIDX_W-1:0] r;
        if (m == ABI_STD) begin
            if (k == 4'd0)      r = 4'd1;
            else if (k < 4'd4)  r = 4'd4 + k;
            else                r = 4'd6 + k;
        end else begin
            if (k == 4'd0)      r = 4'd5;
            else if (k < 4'd5)  r = 4'd9 + k;
            else                r = 4'd15;
        end
        return r;
    endfunction

endpackage

// File: rtl/ctx_nest.sv
module ctx_nest
    import ctx_stack_pkg::*;
#(
    parameter int NEST_MAX = 2,
    localparam int DEPTH_W = $clog2(NEST_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               entry_req,
    input  logic               return_req,
    input  logic               abi_sel,
    input  logic               busy,
    input  logic               fin,
    output logic               start_save,
    output logic               start_restore,
    output abi_e               seq_mode,
    output logic [DEPTH_W-1:0] depth,
    output logic               overflow,
    output logic               underflow
);

    logic [DEPTH_W-1:0] depth_q;
    logic               op_save_q;
    abi_e               op_mode_q;
    abi_e               lvl_q [NEST_MAX];
    logic [NEST_MAX-1:0] lvl_wr;
    abi_e               ret_mode;
    logic               full, empty, ent_seen, ret_seen;

    assign full     = (depth_q == DEPTH_W'(NEST_MAX));
    assign empty    = (depth_q == '0);
    assign ent_seen = !busy && entry_req;
    assign ret_seen = !busy && !entry_req && return_req;

    assign start_save    = ent_seen && !full;
    assign start_restore = ret_seen && !empty;

    // one write strobe per nesting level
    for (genvar g = 0; g < NEST_MAX; g++) begin : g_lvl
        assign lvl_wr[g] = fin && op_save_q && (depth_q == DEPTH_W'(g));
    end

    always_comb begin
        ret_mode = ABI_STD;
        for (int g = 0; g < NEST_MAX; g++) begin
            if (depth_q == DEPTH_W'(g + 1)) ret_mode = lvl_q[g];
        end
    end

    assign seq_mode = start_save ? abi_e'(abi_sel) : ret_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q   <= '0;
            op_save_q <= 1'b0;
            op_mode_q <= ABI_STD;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            for (int g = 0; g < NEST_MAX; g++) lvl_q[g] <= ABI_STD;
        end else begin
            overflow  <= ent_seen && full;
            underflow <= ret_seen && empty;
            if (start_save) begin
                op_save_q <= 1'b1;
                op_mode_q <= abi_e'(abi_sel);
            end else if (start_restore) begin
                op_save_q <= 1'b0;
            end
            for (int g = 0; g < NEST_MAX; g++) begin
                if (lvl_wr[g]) lvl_q[g] <= op_mode_q;
            end
            if (fin) begin
                if (op_save_q) depth_q <= depth_q + 1'b1;
                else           depth_q <= depth_q - 1'b1;
            end
        end
    end

    assign depth = depth_q;

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_stack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_save,
    input  logic              start_restore,
    input  abi_e              seq_mode,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              fin
);

    ctx_state_e        state_q, state_d;
    logic [3:0]        slot_q, slot_d;
    logic [ADDR_W-1:0] base_q, base_d;
    abi_e              mode_q;
    logic [3:0]        nslots;
    logic [ADDR_W-1:0] frame_bytes, slot_off;
    logic              last_slot;

    assign nslots      = slot_count(mode_q);
    assign frame_bytes = ADDR_W'(nslots) << 2;
    assign slot_off    = ADDR_W'(slot_q) << 2;
    assign last_slot   = (slot_q == nslots - 4'd1);

    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        base_d    = base_q;
        rf_raddr  = SP_IDX;
        rf_we     = 1'b0;
        rf_waddr  = SP_IDX;
        rf_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fin       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                slot_d = '0;
                if (start_save)         state_d = ST_SP_DEC;
                else if (start_restore) state_d = ST_SP_GET;
            end
            ST_SP_DEC: begin
                base_d   = ADDR_W'(rf_rdata) - frame_bytes;
                rf_we    = 1'b1;
                rf_wdata = DATA_W'(base_d);
                state_d  = ST_STORE;
            end
            ST_STORE: begin
                rf_raddr  = slot_reg(mode_q, slot_q);
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q + slot_off;
                mem_wdata = rf_rdata;
                if (mem_ready) begin
                    if (last_slot) state_d = ST_DONE;
                    else           slot_d  = slot_q + 4'd1;
                end
            end
            ST_SP_GET: begin
                base_d  = ADDR_W'(rf_rdata);
                state_d = ST_LOAD;
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = base_q + slot_off;
                if (mem_ready) begin
                    rf_we    = 1'b1;
                    rf_waddr = slot_reg(mode_q, slot_q);
                    rf_wdata = mem_rdata;
                    if (last_slot) state_d = ST_SP_INC;
                    else           slot_d  = slot_q + 4'd1;
                end
            end
            ST_SP_INC: begin
                rf_we    = 1'b1;
                rf_wdata = DATA_W'(base_q + frame_bytes);
                state_d  = ST_DONE;
            end
            ST_DONE: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            base_q  <= '0;
            mode_q  <= ABI_STD;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            base_q  <= base_d;
            if (state_q == ST_IDLE && (start_save || start_restore)) mode_q <= seq_mode;
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ctx_stack_engine.sv
module ctx_stack_engine
    import ctx_stack_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int NEST_MAX = 2,
    localparam int DEPTH_W = $clog2(NEST_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               entry_req,
    input  logic               return_req,
    input  logic               abi_sel,
    output logic [3:0]         rf_raddr,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               rf_we,
    output logic [3:0]         rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               done,
    output logic [DEPTH_W-1:0] depth,
    output logic               overflow,
    output logic               underflow
);

    logic start_save, start_restore, fin;
    abi_e seq_mode;

    ctx_nest #(.NEST_MAX(NEST_MAX)) u_nest (
        .clk           (clk),
        .rst           (rst),
        .entry_req     (entry_req),
        .return_req    (return_req),
        .abi_sel       (abi_sel),
        .busy          (busy),
        .fin           (fin),
        .start_save    (start_save),
        .start_restore (start_restore),
        .seq_mode      (seq_mode),
        .depth         (depth),
        .overflow      (overflow),
        .underflow     (underflow)
    );

    ctx_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_save    (start_save),
        .start_restore (start_restore),
        .seq_mode      (seq_mode),
        .rf_raddr      (rf_raddr),
        .rf_rdata      (rf_rdata),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready),
        .busy          (busy),
        .fin           (fin)
    );

    assign done = fin;

endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk #(
    parameter int ADDR_W   = 32,
    parameter int NEST_MAX = 2,
    localparam int DEPTH_W = $clog2(NEST_MAX + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               rf_we,
    input logic [3:0]         rf_waddr,
    input logic               mem_req,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ready,
    input logic               busy,
    input logic               done,
    input logic [DEPTH_W-1:0] depth,
    input logic               overflow,
    input logic               underflow
);

    a_r3_skip_callee: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != 4'd8 && rf_waddr != 4'd9));

    a_r4_word_align: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r4_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r6_depth_max: assert property (@(posedge clk) disable iff (rst)
        depth <= DEPTH_W'(NEST_MAX));

    a_r6_depth_on_done: assert property (@(posedge clk) disable iff (rst)
        (depth != $past(depth)) |-> $past(done));

    a_r7_overflow_quiet: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (depth == DEPTH_W'(NEST_MAX) && !busy && !mem_req));

    a_r8_underflow_quiet: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (depth == '0 && !busy && !mem_req));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we));

endmodule

bind ctx_stack_engine ctx_stack_chk #(.ADDR_W(ADDR_W), .NEST_MAX(NEST_MAX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .depth     (depth),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/sim_ctx_stack_engine.sv
`timescale 1ns/1ps
module sim_ctx_stack_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        entry_req = 1'b0, return_req = 1'b0, abi_sel = 1'b0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
    logic        rf_we, mem_req, mem_we, mem_ready, busy, done, overflow, underflow;
    logic [1:0]  depth;

    always #2.5 clk = ~clk;

    ctx_stack_engine u0 (
        .clk(clk), .rst(rst), .entry_req(entry_req), .return_req(return_req),
        .abi_sel(abi_sel), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .depth(depth),
        .overflow(overflow), .underflow(underflow)
    );

    // surrounding register file and RAM models
    logic [31:0] rf  [16];
    logic [31:0] mem [64];
    logic [3:0]  stall_cnt = '0;
    logic        stall_on  = 1'b0;
    int          acc_cnt = 0, done_cnt = 0;

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_ready = !stall_on || (stall_cnt[1:0] == 2'b00);

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 4'd1;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    int n_chk = 0, n_fail = 0;
    int std_list [10] = '{1, 5, 6, 7, 10, 11, 12, 13, 14, 15};
    int emb_list [6]  = '{5, 10, 11, 12, 13, 15};
    logic [31:0] snap [2][16];
    logic        snap_mode [2];
    logic        ov_seen, un_seen;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int set_len(input logic m);
        return m ? 6 : 10;
    endfunction

    function automatic int set_reg(input logic m, input int k);
        return m ? emb_list[k] : std_list[k];
    endfunction

    function automatic bit in_set(input logic m, input int r);
        for (int k = 0; k < set_len(m); k++) if (set_reg(m, k) == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic pulse(input bit ent, input bit ret, input logic m);
        @(negedge clk);
        entry_req = ent; return_req = ret; abi_sel = m;
        @(negedge clk);
        ov_seen = overflow; un_seen = underflow;
        entry_req = 1'b0; return_req = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R5 done reached", {31'd0, done}, 32'd1);
        @(negedge clk);
    endtask

    task automatic fill_regs(input logic [31:0] tag);
        @(negedge clk);
        for (int i = 0; i < 16; i++) if (i != 2) rf[i] = tag + 32'(i);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R5 reset busy", {31'd0, busy}, 32'd0);
        chk(done == 1'b0, "R5 reset done", {31'd0, done}, 32'd0);
        chk(mem_req == 1'b0, "R5 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk(depth == 2'd0, "R6 reset depth", {30'd0, depth}, 32'd0);
    endtask

    task automatic t_save(input logic m, input string req);
        int lvl = int'(depth);
        logic [31:0] sp0 = rf[2];
        int a0, d0, n;
        n = set_len(m);
        for (int i = 0; i < 16; i++) snap[lvl][i] = rf[i];
        snap_mode[lvl] = m;
        a0 = acc_cnt; d0 = done_cnt;
        pulse(1'b1, 1'b0, m);
        chk(busy == 1'b1, "R5 busy after accept", {31'd0, busy}, 32'd1);
        wait_done();
        chk(rf[2] == sp0 - 32'(4 * n), "R4 sp lowered", rf[2], sp0 - 32'(4 * n));
        for (int k = 0; k < n; k++)
            chk(mem[rf[2][7:2] + 6'(k)] == snap[lvl][set_reg(m, k)], req,
                mem[rf[2][7:2] + 6'(k)], snap[lvl][set_reg(m, k)]);
        chk(acc_cnt - a0 == n, {req, " access count"}, 32'(acc_cnt - a0), 32'(n));
        chk(done_cnt - d0 == 1, "R5 single done", 32'(done_cnt - d0), 32'd1);
        chk(int'(depth) == lvl + 1, "R6 depth up", {30'd0, depth}, 32'(lvl + 1));
        chk(busy == 1'b0, "R5 idle after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_restore(input logic m_now, input string req);
        int lvl = int'(depth) - 1;
        logic [31:0] sp0 = rf[2];
        logic [31:0] junk [16];
        logic        m = snap_mode[lvl];
        int a0, n;
        n = set_len(m);
        fill_regs(32'hA500_0000 + 32'(lvl) * 32'h100);
        for (int i = 0; i < 16; i++) junk[i] = rf[i];
        a0 = acc_cnt;
        pulse(1'b0, 1'b1, m_now);
        wait_done();
        for (int i = 1; i < 16; i++) begin
            if (i == 2) continue;
            if (in_set(m, i)) chk(rf[i] == snap[lvl][i], req, rf[i], snap[lvl][i]);
            else chk(rf[i] == junk[i], "R3 untouched reg", rf[i], junk[i]);
        end
        chk(rf[2] == sp0 + 32'(4 * n), "R4 sp raised", rf[2], sp0 + 32'(4 * n));
        chk(acc_cnt - a0 == n, {req, " load count"}, 32'(acc_cnt - a0), 32'(n));
        chk(int'(depth) == lvl, "R6 depth down", {30'd0, depth}, 32'(lvl));
    endtask

    task automatic t_refuse(input bit ent, input string req);
        int a0 = acc_cnt;
        logic [1:0] d0 = depth;
        pulse(ent, !ent, 1'b0);
        chk((ent ? ov_seen : un_seen) == 1'b1, req, {31'd0, ent ? ov_seen : un_seen}, 32'd1);
        @(negedge clk);
        chk((ent ? overflow : underflow) == 1'b0, {req, " one cycle"},
            {31'd0, ent ? overflow : underflow}, 32'd0);
        repeat (3) @(negedge clk);
        chk(acc_cnt == a0, {req, " no traffic"}, 32'(acc_cnt - a0), 32'd0);
        chk(depth == d0, {req, " depth kept"}, {30'd0, depth}, {30'd0, d0});
    endtask

    task automatic t_busy_ignore();
        int a0 = acc_cnt;
        fill_regs(32'h5100_0000);
        pulse(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        entry_req = 1'b1; return_req = 1'b1;
        repeat (3) @(negedge clk);
        entry_req = 1'b0; return_req = 1'b0;
        wait_done();
        chk(acc_cnt - a0 == 6, "R10 requests ignored while busy", 32'(acc_cnt - a0), 32'd6);
        chk(depth == 2'd1, "R10 depth after ignored requests", {30'd0, depth}, 32'd1);
        snap_mode[0] = 1'b1;
        for (int i = 0; i < 16; i++) snap[0][i] = 32'h5100_0000 + 32'(i);
        snap[0][2] = rf[2] + 32'd24;
        t_restore(1'b0, "R2 restore after ignore");
    endtask

    task automatic t_both_req();
        fill_regs(32'h7700_0000);
        for (int i = 0; i < 16; i++) snap[0][i] = rf[i];
        snap_mode[0] = 1'b0;
        pulse(1'b1, 1'b1, 1'b0);
        wait_done();
        chk(depth == 2'd1, "R10 entry wins", {30'd0, depth}, 32'd1);
        t_restore(1'b1, "R1 restore after dual request");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i);
        rf[2] = 32'h0000_0100;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_save(1'b0, "R1 std slot");
        t_restore(1'b1, "R1 std restore");
        stall_on = 1'b1;
        fill_regs(32'h2200_0000);
        t_save(1'b1, "R2 emb slot");
        t_restore(1'b0, "R2 emb restore");
        t_refuse(1'b0, "R8 underflow");
        fill_regs(32'h3300_0000);
        t_save(1'b0, "R9 outer std slot");
        fill_regs(32'h4400_0000);
        t_save(1'b1, "R9 inner emb slot");
        t_refuse(1'b1, "R7 overflow");
        t_restore(1'b0, "R9 inner restore uses recorded set");
        t_restore(1'b1, "R9 outer restore uses recorded set");
        t_busy_ignore();
        t_both_req();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule